// File: doc/BRIEF.md
# Prioritized Memory Region Protection Unit

This block classifies every memory access against a small bank of programmable address regions. Each region holds a base address, a power-of-two size, a valid bit, a permission code, an execute-never bit and a memory-attribute word. Regions may overlap, and when several of them match, the one with the highest index wins. The block returns the winning attributes, an execute-never flag and a permission fault. It registers these results, so they appear one cycle after the request.

If no region matches, or the unit is disabled, or it was built without regions, the attributes come from a fixed default address map. The attributes in that map depend on the top address bits, on whether the access is an instruction fetch, on the two cache-enable inputs and on a high-vectors strap. Software programs the regions and the global enable through a small register port. That port answers only when a privileged flag comes with the access.

Top module: `prio_region_guard`

## Requirements
- R1: The region count NUM_REGIONS is a build parameter of 0, 8 or 12. With 0 regions the enable can never be set and every register read returns 0. Every lookup then gets the default map with rspHit=0 and rspFault=0.
- R2: A region matches when the address equals the base under a mask that clears the low `size` address bits. The size exponent sits in attribute word bits 5:1 and is treated as 5 (32 bytes) when it is below 5. The low base bits are ignored, so an unaligned base is matched as if it were aligned.
- R3: When several valid regions match, rspRegion, rspAttr, rspXn and the permission check come from the highest-indexed one.
- R4: Register port: cfgAddr 0 is control (bit 0 = enable). cfgAddr with bit 5 set addresses a region: bits 4:1 hold the index and bit 0 picks the word. Word 0 is the base (bits 31:5, lower bits read 0). Word 1 holds bit0 valid, bits5:1 size exponent, bits7:6 permission, bit8 execute-never and bits13:9 attributes. Indices at or above NUM_REGIONS are ignored and read 0. An access without cfgPriv changes nothing, reads 0 and raises cfgDenied in the same cycle.
- R5: While the unit is disabled, every lookup uses the default map, rspHit=0 and rspFault=0.
- R6: While the unit is enabled and no valid region matches, a privileged access gets the default map and no fault. An unprivileged access gets the default map attributes and rspFault=1.
- R7: Permission code 0 faults every access. Code 1 faults unprivileged accesses. Code 2 allows everything. Code 3 faults writes only. The fault appears together with the lookup result.
- R8: Default map, addresses 0xF0000000 and up: a fetch gets Normal non-shared non-cacheable, and a data access gets Strongly Ordered shared. In both cases rspXn = NOT hiVecs.
- R9: Default map: 0xC0000000–0xEFFFFFFF is Strongly Ordered shared, 0xA0000000–0xBFFFFFFF is shared Device, and 0x80000000–0x9FFFFFFF is non-shared Device. All of these ranges have rspXn=1.
- R10: Default map below 0x80000000 has rspXn=0. A fetch is Normal non-shared, write-through when icacheEn=1 and non-cacheable otherwise. A data access is Normal shared non-cacheable when dcacheEn=0. When dcacheEn=1 it depends on the range: 0x60000000–0x7FFFFFFF is shared non-cacheable, 0x40000000–0x5FFFFFFF is non-shared write-through, and below 0x40000000 is non-shared write-back write-allocate.
- R11: rspValid is high exactly in the cycle after a cycle with reqValid high. The other response outputs belong to that request. rspValid is 0 after reset.
- R12: rspAttr encoding: bits 1:0 give the kind (0 strongly ordered, 1 device, 2 normal), bit 2 is shared, and bits 4:3 give the cache policy (0 none, 1 write-through, 2 write-back write-allocate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgValid | input | 1 | Register access strobe |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgPriv | input | 1 | Access carries privileged mode |
| cfgAddr | input | 6 | Register address |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, same cycle |
| cfgDenied | output | 1 | Unprivileged register access flag |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Access address |
| reqWrite | input | 1 | Access is a write |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqPriv | input | 1 | Access is privileged |
| icacheEn | input | 1 | Instruction cache enabled |
| dcacheEn | input | 1 | Data cache enabled |
| hiVecs | input | 1 | High-vectors strap |
| rspValid | output | 1 | Result valid |
| rspHit | output | 1 | A region matched |
| rspRegion | output | 4 | Winning region index |
| rspAttr | output | 5 | Memory attributes (R12) |
| rspXn | output | 1 | Execute-never |
| rspFault | output | 1 | Permission or background fault |

## Verification
A bad stored field or a bad priority choice shows up on the first lookup that reaches the affected region. That lookup's response, one cycle after the request, carries a wrong rspRegion, rspAttr or rspFault. A lost enable or valid bit is seen on any in-range lookup, where the response falls back to the default map or takes a background fault. The bench therefore aims random addresses inside and just past programmed regions that overlap. It sweeps every default-map range under all strap combinations. A bad register state is visible at once through the read port.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  localparam int ADDR_W  = 32;
  localparam int LOW_W   = 5;
  localparam int SIZE_W  = 5;
  localparam int IDX_W   = 4;
  localparam int CADDR_W = 6;
  localparam int BASE_W  = ADDR_W - LOW_W;

  typedef enum logic [1:0] {
    KIND_STRONG = 2'd0,
    KIND_DEVICE = 2'd1,
    KIND_NORMAL = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    CACHE_NONE = 2'd0,
    CACHE_WT   = 2'd1,
    CACHE_WBWA = 2'd2
  } cache_e;

  typedef struct packed {
    cache_e cache;
    logic   shared;
    kind_e  kind;
  } memAttr_t;

  typedef struct packed {
    logic     xn;
    memAttr_t attr;
  } lookup_t;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_PRIV = 2'd1;
  localparam logic [1:0] PERM_FULL = 2'd2;
  localparam logic [1:0] PERM_RO   = 2'd3;

  typedef struct packed {
    logic               enWr;
    logic               baseWr;
    logic               attrWr;
    logic               rdCtl;
    logic               rdBase;
    logic               rdAttr;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  data;
    logic               capture;
  } strobe_t;

  function automatic lookup_t defaultMap(input logic [3:0] top,
                                         input logic fetch,
                                         input logic icEn,
                                         input logic dcEn,
                                         input logic hv);
    lookup_t r;
    r.xn = 1'b0;
    r.attr = '{cache: CACHE_NONE, shared: 1'b0, kind: KIND_NORMAL};
    if (top == 4'hF) begin
      r.xn = !hv;
      if (fetch) r.attr = '{cache: CACHE_NONE, shared: 1'b0, kind: KIND_NORMAL};
      else       r.attr = '{cache: CACHE_NONE, shared: 1'b1, kind: KIND_STRONG};
    end else if (top >= 4'hC) begin
      r.xn = 1'b1;
      r.attr = '{cache: CACHE_NONE, shared: 1'b1, kind: KIND_STRONG};
    end else if (top >= 4'hA) begin
      r.xn = 1'b1;
      r.attr = '{cache: CACHE_NONE, shared: 1'b1, kind: KIND_DEVICE};
    end else if (top >= 4'h8) begin
      r.xn = 1'b1;
      r.attr = '{cache: CACHE_NONE, shared: 1'b0, kind: KIND_DEVICE};
    end else if (fetch) begin
      r.attr = '{cache: (icEn ? CACHE_WT : CACHE_NONE), shared: 1'b0, kind: KIND_NORMAL};
    end else if (!dcEn || top >= 4'h6) begin
      r.attr = '{cache: CACHE_NONE, shared: 1'b1, kind: KIND_NORMAL};
    end else if (top >= 4'h4) begin
      r.attr = '{cache: CACHE_WT, shared: 1'b0, kind: KIND_NORMAL};
    end else begin
      r.attr = '{cache: CACHE_WBWA, shared: 1'b0, kind: KIND_NORMAL};
    end
    return r;
  endfunction

endpackage

// File: rtl/rgn_ctrl.sv
module rgn_ctrl
  import rgn_pkg::*;
#(
  parameter int NUM_REGIONS = 12
) (
  input  logic               cfgValid,
  input  logic               cfgWrite,
  input  logic               cfgPriv,
  input  logic [CADDR_W-1:0] cfgAddr,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic               reqValid,
  output strobe_t            stb,
  output logic               cfgDenied
);

  localparam bit HAS_RGN = (NUM_REGIONS > 0);

  logic allowed;
  logic isCtl;
  logic isRegion;
  logic idxOk;
  logic wordSel;

  assign allowed  = cfgValid && cfgPriv && HAS_RGN;
  assign isCtl    = (cfgAddr == '0);
  assign isRegion = cfgAddr[CADDR_W-1];
  assign idxOk    = int'(cfgAddr[IDX_W:1]) < NUM_REGIONS;
  assign wordSel  = cfgAddr[0];

  always_comb begin
    stb         = '0;
    stb.idx     = cfgAddr[IDX_W:1];
    stb.data    = cfgWdata;
    stb.capture = reqValid;
    if (allowed) begin
      if (cfgWrite) begin
        stb.enWr   = isCtl;
        stb.baseWr = isRegion && idxOk && !wordSel;
        stb.attrWr = isRegion && idxOk && wordSel;
      end else begin
        stb.rdCtl  = isCtl;
        stb.rdBase = isRegion && idxOk && !wordSel;
        stb.rdAttr = isRegion && idxOk && wordSel;
      end
    end
  end

  assign cfgDenied = cfgValid && !cfgPriv;

endmodule

// File: rtl/rgn_datapath.sv
module rgn_datapath
  import rgn_pkg::*;
#(
  parameter int NUM_REGIONS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic              reqPriv,
  input  logic              icacheEn,
  input  logic              dcacheEn,
  input  logic              hiVecs,
  output logic [ADDR_W-1:0] cfgRdata,
  output logic              rspValid,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspRegion,
  output memAttr_t          rspAttr,
  output logic              rspXn,
  output logic              rspFault
);

  localparam int NR      = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS;
  localparam bit HAS_RGN = (NUM_REGIONS > 0);
  localparam int PAD_W   = ADDR_W - 14;

  logic                 enableQ;
  logic [BASE_W-1:0]    baseArr [NR];
  logic                 valArr  [NR];
  logic [SIZE_W-1:0]    sizeArr [NR];
  logic [1:0]           permArr [NR];
  logic                 xnArr   [NR];
  memAttr_t             attrArr [NR];
  logic [NR-1:0]        hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    enableQ <= 1'b0;
    else if (HAS_RGN && stb.enWr) enableQ <= stb.data[0];
  end

  for (genvar g = 0; g < NR; g++) begin : g_rgn
    logic [BASE_W-1:0] baseQ;
    logic              valQ;
    logic [SIZE_W-1:0] sizeQ;
    logic [1:0]        permQ;
    logic              xnQ;
    memAttr_t          attrQ;
    logic [SIZE_W-1:0] effLog2;
    logic [ADDR_W-1:0] mask;
    logic              selMe;

    assign selMe = HAS_RGN && (stb.idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        valQ  <= 1'b0;
        sizeQ <= '0;
        permQ <= PERM_NONE;
        xnQ   <= 1'b0;
        attrQ <= '0;
      end else begin
        if (selMe && stb.baseWr) baseQ <= stb.data[ADDR_W-1:LOW_W];
        if (selMe && stb.attrWr) begin
          valQ  <= stb.data[0];
          sizeQ <= stb.data[5:1];
          permQ <= stb.data[7:6];
          xnQ   <= stb.data[8];
          attrQ <= memAttr_t'(stb.data[13:9]);
        end
      end
    end

    assign effLog2 = (sizeQ < SIZE_W'(LOW_W)) ? SIZE_W'(LOW_W) : sizeQ;
    assign mask    = {ADDR_W{1'b1}} << effLog2;
    assign hitVec[g] = HAS_RGN && enableQ && valQ &&
                       ((reqAddr & mask) == ({baseQ, {LOW_W{1'b0}}} & mask));

    assign baseArr[g] = baseQ;
    assign valArr[g]  = valQ;
    assign sizeArr[g] = sizeQ;
    assign permArr[g] = permQ;
    assign xnArr[g]   = xnQ;
    assign attrArr[g] = attrQ;
  end

  // Fixed priority: later (higher) indices override earlier ones.
  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  memAttr_t         winAttr;
  logic             winXn;
  logic [1:0]       winPerm;

  always_comb begin
    anyHit  = 1'b0;
    winIdx  = '0;
    winAttr = '0;
    winXn   = 1'b0;
    winPerm = PERM_NONE;
    for (int i = 0; i < NR; i++) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        winIdx  = IDX_W'(i);
        winAttr = attrArr[i];
        winXn   = xnArr[i];
        winPerm = permArr[i];
      end
    end
  end

  logic permFault;
  always_comb begin
    unique case (winPerm)
      PERM_PRIV: permFault = !reqPriv;
      PERM_FULL: permFault = 1'b0;
      PERM_RO:   permFault = reqWrite;
      default:   permFault = 1'b1;
    endcase
  end

  lookup_t  dm;
  memAttr_t nextAttr;
  logic     nextXn;
  logic     nextFault;

  assign dm = defaultMap(reqAddr[ADDR_W-1 -: 4], reqFetch, icacheEn, dcacheEn, hiVecs);

  always_comb begin
    if (anyHit) begin
      nextAttr  = winAttr;
      nextXn    = winXn;
      nextFault = permFault;
    end else begin
      nextAttr  = dm.attr;
      nextXn    = dm.xn;
      nextFault = enableQ && !reqPriv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspRegion <= '0;
      rspAttr   <= '0;
      rspXn     <= 1'b0;
      rspFault  <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspHit    <= anyHit;
        rspRegion <= winIdx;
        rspAttr   <= nextAttr;
        rspXn     <= nextXn;
        rspFault  <= nextFault;
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (stb.rdCtl) cfgRdata[0] = enableQ;
    for (int i = 0; i < NR; i++) begin
      if (stb.idx == IDX_W'(i)) begin
        if (stb.rdBase) cfgRdata = {baseArr[i], {LOW_W{1'b0}}};
        if (stb.rdAttr) cfgRdata = {{PAD_W{1'b0}}, attrArr[i], xnArr[i],
                                    permArr[i], sizeArr[i], valArr[i]};
      end
    end
  end

  // R1: without regions nothing can ever hit
  p_zero_no_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!HAS_RGN && stb.capture) |=> !rspHit);

  // R5: disabled unit never hits nor faults
  p_off_no_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !enableQ) |=> (!rspHit && !rspFault));

  // R6: enabled, no hit, unprivileged -> background fault
  p_bg_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && enableQ && !anyHit && !reqPriv) |=> rspFault);

  // R7: no-access winner always faults
  p_no_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && anyHit && winPerm == PERM_NONE) |=> rspFault);

  // R9: device / strongly ordered default ranges are execute-never
  p_io_xn_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !anyHit && reqAddr[ADDR_W-1 -: 4] >= 4'h8 &&
     reqAddr[ADDR_W-1 -: 4] <= 4'hE) |=> rspXn);

endmodule

// File: rtl/prio_region_guard.sv
module prio_region_guard
  import rgn_pkg::*;
#(
  parameter int NUM_REGIONS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic        cfgPriv,
  input  logic [5:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        cfgDenied,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic        reqFetch,
  input  logic        reqPriv,
  input  logic        icacheEn,
  input  logic        dcacheEn,
  input  logic        hiVecs,
  output logic        rspValid,
  output logic        rspHit,
  output logic [3:0]  rspRegion,
  output logic [4:0]  rspAttr,
  output logic        rspXn,
  output logic        rspFault
);

  strobe_t  stb;
  memAttr_t attrOut;

  rgn_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .cfgValid (cfgValid),
    .cfgWrite (cfgWrite),
    .cfgPriv  (cfgPriv),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .reqValid (reqValid),
    .stb      (stb),
    .cfgDenied(cfgDenied)
  );

  rgn_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqFetch (reqFetch),
    .reqPriv  (reqPriv),
    .icacheEn (icacheEn),
    .dcacheEn (dcacheEn),
    .hiVecs   (hiVecs),
    .cfgRdata (cfgRdata),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspRegion(rspRegion),
    .rspAttr  (attrOut),
    .rspXn    (rspXn),
    .rspFault (rspFault)
  );

  assign rspAttr = attrOut;

  // R4: unprivileged register access reads nothing and is flagged
  p_unpriv_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgPriv) |-> (cfgDenied && cfgRdata == '0));

  // R11: response follows request by one cycle
  p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_resp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: tb/prio_region_guard_tb.sv
`timescale 1ns/1ps
module prio_region_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 0, cfgWrite = 0, cfgPriv = 0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        reqValid = 0, reqWrite = 0, reqFetch = 0, reqPriv = 0;
  logic [31:0] reqAddr = '0;
  logic        icacheEn = 0, dcacheEn = 0, hiVecs = 0;

  logic [31:0] cfgRdata, zRdata;
  logic        cfgDenied, zDenied;
  logic        rspValid, rspHit, rspXn, rspFault;
  logic        zValid, zHit, zXn, zFault;
  logic [3:0]  rspRegion, zRegion;
  logic [4:0]  rspAttr, zAttr;

  always #2 clk = ~clk;

  prio_region_guard #(.NUM_REGIONS(12)) u_dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgPriv(cfgPriv),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgDenied(cfgDenied),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqPriv(reqPriv), .icacheEn(icacheEn), .dcacheEn(dcacheEn), .hiVecs(hiVecs),
    .rspValid(rspValid), .rspHit(rspHit), .rspRegion(rspRegion), .rspAttr(rspAttr),
    .rspXn(rspXn), .rspFault(rspFault));

  prio_region_guard #(.NUM_REGIONS(0)) u_dut_zero (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgPriv(cfgPriv),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(zRdata), .cfgDenied(zDenied),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqPriv(reqPriv), .icacheEn(icacheEn), .dcacheEn(dcacheEn), .hiVecs(hiVecs),
    .rspValid(zValid), .rspHit(zHit), .rspRegion(zRegion), .rspAttr(zAttr),
    .rspXn(zXn), .rspFault(zFault));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the programmed state
  logic [31:0] mBase [12];
  bit          mVal  [12];
  logic [4:0]  mSize [12];
  logic [1:0]  mPerm [12];
  bit          mXn   [12];
  logic [4:0]  mAttr [12];
  bit          mEn;

  typedef struct packed {
    logic       hit;
    logic [3:0] rgn;
    logic       xn;
    logic [4:0] attr;
    logic       fault;
  } exp_t;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R12 encoding: {cache[1:0], shared, kind[1:0]}
  function automatic logic [5:0] dmap(input logic [31:0] a, input logic fe,
                                      input logic ic, input logic dc, input logic hv);
    logic [3:0] t;
    t = a[31:28];
    if (t == 4'hF) return fe ? {~hv, 5'b00_0_10} : {~hv, 5'b00_1_00};
    if (t >= 4'hC) return {1'b1, 5'b00_1_00};
    if (t >= 4'hA) return {1'b1, 5'b00_1_01};
    if (t >= 4'h8) return {1'b1, 5'b00_0_01};
    if (fe)        return {1'b0, ic ? 5'b01_0_10 : 5'b00_0_10};
    if (!dc)       return {1'b0, 5'b00_1_10};
    if (t >= 4'h6) return {1'b0, 5'b00_1_10};
    if (t >= 4'h4) return {1'b0, 5'b01_0_10};
    return {1'b0, 5'b10_0_10};
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic wr, input logic fe,
                                 input logic pv);
    exp_t e;
    int lg;
    logic [31:0] m;
    e = '0;
    for (int i = 0; i < 12; i++) begin
      if (mEn && mVal[i]) begin
        lg = (mSize[i] < 5) ? 5 : int'(mSize[i]);
        m = 32'hFFFF_FFFF << lg;
        if ((a & m) == (mBase[i] & m)) begin
          e.hit = 1'b1;
          e.rgn = 4'(i);
        end
      end
    end
    if (e.hit) begin
      e.xn = mXn[e.rgn];
      e.attr = mAttr[e.rgn];
      case (mPerm[e.rgn])
        2'd0: e.fault = 1'b1;
        2'd1: e.fault = !pv;
        2'd2: e.fault = 1'b0;
        default: e.fault = wr;
      endcase
    end else begin
      {e.xn, e.attr} = dmap(a, fe, icacheEn, dcacheEn, hiVecs);
      e.fault = mEn && !pv;
    end
    return e;
  endfunction

  task automatic cfgWr(input logic [5:0] a, input logic [31:0] d, input logic pv);
    int idx;
    @(negedge clk);
    cfgValid = 1; cfgWrite = 1; cfgPriv = pv; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgValid = 0; cfgWrite = 0;
    idx = int'(a[4:1]);
    if (pv) begin
      if (a == 6'd0) mEn = d[0];
      else if (a[5] && idx < 12) begin
        if (!a[0]) mBase[idx] = d & 32'hFFFF_FFE0;
        else begin
          mVal[idx] = d[0]; mSize[idx] = d[5:1]; mPerm[idx] = d[7:6];
          mXn[idx] = d[8]; mAttr[idx] = d[13:9];
        end
      end
    end
  endtask

  task automatic cfgRd(input logic [5:0] a, input logic pv, output logic [31:0] d,
                       output logic den, output logic [31:0] zd);
    @(negedge clk);
    cfgValid = 1; cfgWrite = 0; cfgPriv = pv; cfgAddr = a;
    #1;
    d = cfgRdata; den = cfgDenied; zd = zRdata;
    cfgValid = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic wr, input logic fe,
                        input logic pv, input string tag);
    exp_t e;
    logic [5:0] d;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = wr; reqFetch = fe; reqPriv = pv;
    e = model(a, wr, fe, pv);
    d = dmap(a, fe, icacheEn, dcacheEn, hiVecs);
    @(negedge clk);
    reqValid = 0;
    chk({tag, " R11 valid"}, 32'(rspValid), 32'd1);
    chk({tag, " hit"}, 32'(rspHit), 32'(e.hit));
    if (e.hit) chk({tag, " R3 region"}, 32'(rspRegion), 32'(e.rgn));
    chk({tag, " R12 attr"}, 32'(rspAttr), 32'(e.attr));
    chk({tag, " xn"}, 32'(rspXn), 32'(e.xn));
    chk({tag, " R7 fault"}, 32'(rspFault), 32'(e.fault));
    chk({tag, " R1 zero attr"}, 32'({zHit, zFault, zXn, zAttr}), 32'({2'b00, d}));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, zrd;
    logic den;
    mEn = 0;
    for (int i = 0; i < 12; i++) begin
      mBase[i] = '0; mVal[i] = 0; mSize[i] = '0; mPerm[i] = '0; mXn[i] = 0; mAttr[i] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    chk("R11 reset valid", 32'(rspValid), 32'd0);
    cfgRd(6'd0, 1, rd, den, zrd);
    chk("R4 reset enable", rd, 32'd0);

    // R5 / R8 / R9 / R10: sweep default map while disabled
    for (int t = 0; t < 16; t++) begin
      for (int s = 0; s < 8; s++) begin
        icacheEn = s[0]; dcacheEn = s[1]; hiVecs = s[2];
        lookup({4'(t), 28'h0123450}, 1'b0, 1'b0, 1'b0, "R5 R9 R10 R8 map data");
        lookup({4'(t), 28'hFEDCBA0}, 1'b1, 1'b1, 1'b1, "R5 R9 R10 R8 map fetch");
      end
    end
    // R11: idle cycle after response
    @(negedge clk);
    chk("R11 idle", 32'(rspValid), 32'd0);

    // R4: unprivileged write ignored and flagged
    @(negedge clk);
    cfgValid = 1; cfgWrite = 1; cfgPriv = 0; cfgAddr = 6'd0; cfgWdata = 32'd1;
    #1;
    chk("R4 denied flag", 32'(cfgDenied), 32'd1);
    @(negedge clk);
    cfgValid = 0;
    cfgRd(6'd0, 1, rd, den, zrd);
    chk("R4 enable unchanged", rd, 32'd0);

    // enable, program overlapping regions
    cfgWr(6'd0, 32'd1, 1);
    cfgWr({1'b1, 4'd2, 1'b0}, 32'h2000_0000, 1);
    cfgWr({1'b1, 4'd2, 1'b1}, {18'b0, 5'b10_0_10, 1'b0, 2'd2, 5'd16, 1'b1}, 1);
    cfgWr({1'b1, 4'd5, 1'b0}, 32'h2000_0000, 1);
    cfgWr({1'b1, 4'd5, 1'b1}, {18'b0, 5'b00_1_01, 1'b1, 2'd1, 5'd12, 1'b1}, 1);
    icacheEn = 1; dcacheEn = 1; hiVecs = 0;
    lookup(32'h2000_0100, 1'b0, 1'b0, 1'b0, "R3 overlap high wins unpriv");
    chk("R3 winner index", 32'(rspRegion), 32'd5);
    chk("R7 priv-only unpriv fault", 32'(rspFault), 32'd1);
    lookup(32'h2000_8000, 1'b1, 1'b0, 1'b0, "R2 R3 outer region");
    chk("R3 outer index", 32'(rspRegion), 32'd2);

    // R2: size clamp and unaligned base
    cfgWr({1'b1, 4'd7, 1'b0}, 32'h3000_0040, 1);
    cfgWr({1'b1, 4'd7, 1'b1}, {18'b0, 5'b0, 1'b0, 2'd3, 5'd0, 1'b1}, 1);
    lookup(32'h3000_005F, 1'b1, 1'b0, 1'b1, "R2 clamp inside");
    chk("R2 clamp hit", 32'(rspHit), 32'd1);
    chk("R7 read-only write", 32'(rspFault), 32'd1);
    lookup(32'h3000_0060, 1'b0, 1'b0, 1'b1, "R2 clamp outside");
    chk("R2 clamp miss", 32'(rspHit), 32'd0);
    cfgWr({1'b1, 4'd9, 1'b0}, 32'h1234_5678, 1);
    cfgWr({1'b1, 4'd9, 1'b1}, {18'b0, 5'b00_0_00, 1'b0, 2'd0, 5'd12, 1'b1}, 1);
    lookup(32'h1234_5000, 1'b0, 1'b0, 1'b1, "R2 unaligned base");
    chk("R2 unaligned hit", 32'(rspHit), 32'd1);
    chk("R7 no access", 32'(rspFault), 32'd1);

    // R6: enabled, no hit
    lookup(32'h5000_0000, 1'b0, 1'b0, 1'b1, "R6 priv background");
    chk("R6 priv no fault", 32'(rspFault), 32'd0);
    lookup(32'h5000_0000, 1'b0, 1'b0, 1'b0, "R6 unpriv background");
    chk("R6 unpriv fault", 32'(rspFault), 32'd1);

    // R4 read-back, out-of-range index, unprivileged read
    cfgRd({1'b1, 4'd5, 1'b1}, 1, rd, den, zrd);
    chk("R4 attr readback", rd, {18'b0, 5'b00_1_01, 1'b1, 2'd1, 5'd12, 1'b1});
    chk("R1 zero readback", zrd, 32'd0);
    cfgRd({1'b1, 4'd9, 1'b0}, 1, rd, den, zrd);
    chk("R4 base readback", rd, 32'h1234_5660);
    cfgRd({1'b1, 4'd5, 1'b1}, 0, rd, den, zrd);
    chk("R4 unpriv read zero", rd, 32'd0);
    chk("R4 unpriv read flag", 32'(den), 32'd1);
    cfgWr({1'b1, 4'd13, 1'b1}, 32'h0000_3FFF, 1);
    cfgRd({1'b1, 4'd13, 1'b1}, 1, rd, den, zrd);
    chk("R4 index out of range", rd, 32'd0);
    cfgRd(6'd0, 1, rd, den, zrd);
    chk("R1 zero enable stays 0", zrd, 32'd0);

    // constrained random programming and lookups
    for (int r = 0; r < 60; r++) begin
      logic [3:0] idx;
      logic [31:0] base, a;
      int lg;
      idx = 4'($urandom_range(0, 11));
      base = $urandom;
      cfgWr({1'b1, idx, 1'b0}, base, 1);
      cfgWr({1'b1, idx, 1'b1},
            {18'b0, 5'($urandom), 1'($urandom), 2'($urandom), 5'($urandom_range(0, 24)),
             1'($urandom_range(0, 7) != 0)}, 1);
      if (r % 15 == 14) cfgWr(6'd0, 32'($urandom_range(0, 3) != 0), 1);
      for (int k = 0; k < 15; k++) begin
        int j;
        j = $urandom_range(0, 11);
        lg = (mSize[j] < 5) ? 5 : int'(mSize[j]);
        if ($urandom_range(0, 3) != 0)
          a = mBase[j] + ($urandom & ((32'd1 << (lg + 1)) - 1));
        else
          a = $urandom;
        icacheEn = 1'($urandom); dcacheEn = 1'($urandom); hiVecs = 1'($urandom);
        lookup(a, 1'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R6 R7 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule